// File: doc/BRIEF.md
# Ten-Channel DMA Request Arbiter with Cascade Links

This block decides which of ten DMA channels owns the next transfer slot. Every channel keeps one sticky pending bit. The bit can be set from one of three sources, chosen per channel: a software trigger, a peripheral strobe, or a cascade link driven by another channel's completed transfer. When no transfer is in flight, the lowest-numbered pending channel is granted. The grant covers exactly one data item. It stays on until the datapath reports completion, and then the bus is released before the next arbitration.

A completion clears the finished channel's pending bit and raises that channel's cascade link, if it has one. The links form two three-channel rings (0, 1, 2 and 5, 6, 7) and two one-way pairs (3 to 4 and 8 to 9). A completion on channel 0 that also reports a count underflow additionally requests channel 5. A link only sets its target when that target is enabled and has cascade selected as its source.

Top module: `dma_req_arbiter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), grant_valid is 0, grant_onehot is 0 and no channel is pending.
- R2: When several channels are pending and the bus is free, the lowest channel number is granted. grant_ch carries the number, and grant_onehot has only bit grant_ch set.
- R3: Per-channel source select (src_sel bits [2i+1:2i]): 2'b00 software trigger, 2'b01 peripheral request, 2'b10 cascade link, 2'b11 no source. A pulse on a source that is not selected leaves the channel unrequested.
- R4: A request pulse of one cycle sets a pending bit that stays set until that channel's transfer completes. A channel that loses arbitration is served later without a new request.
- R5: A completion on channel 0, 1 or 2 requests channel 1, 2 or 0 respectively. A completion on channel 5, 6 or 7 requests channel 6, 7 or 5 respectively.
- R6: A completion on channel 3 requests channel 4, and a completion on channel 8 requests channel 9. Completions on channels 4 and 9 request nothing.
- R7: A completion on channel 0 with xfer_underflow high also requests channel 5. Underflow on any other channel adds no request.
- R8: A channel whose ch_enable bit is 0 ignores every source, cascade links included.
- R9: A grant is held until xfer_done is high at a clock edge. grant_valid is then 0 for one cycle before the next grant. xfer_done while no grant is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 10 | Per-channel enable |
| src_sel | input | 20 | Two-bit source select per channel |
| sw_trig | input | 10 | Software trigger pulses |
| periph_req | input | 10 | Peripheral request strobes |
| xfer_done | input | 1 | Current transfer finished |
| xfer_underflow | input | 1 | Qualifies xfer_done: the channel's count wrapped |
| grant_valid | output | 1 | A channel owns the transfer slot |
| grant_ch | output | 4 | Number of the granted channel |
| grant_onehot | output | 10 | Granted channel as a one-hot vector |

## Verification
A request sampled at edge k sets its pending bit at edge k, and that bit can be granted at edge k+1 at the earliest. The bench therefore checks one cycle after a pulse that no grant has appeared yet, and checks for the grant one cycle after that. A completion at edge m drops the grant and sets the cascade target at edge m. The follow-on grant is due at edge m+1, so each finish step is checked for an idle bus before the next grant is checked. All inputs are driven and all outputs are sampled on the falling edge, which places every check between the edges that matter.

// File: rtl/dmarb_pkg.sv
// Package: shared constants, source-select encoding and the fixed cascade map.
// Assumes exactly ten channels; the cascade map is defined for that count.
package dmarb_pkg;
    localparam int NCH = 10;
    localparam int CHW = $clog2(NCH);
    localparam int SELW = 2;

    typedef enum logic [SELW-1:0] {
        SRC_SW      = 2'b00,
        SRC_PERIPH  = 2'b01,
        SRC_CASCADE = 2'b10,
        SRC_NONE    = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic           valid;
        logic [CHW-1:0] ch;
    } link_t;

    localparam logic [CHW-1:0] UF_SRC_CH = CHW'(0);
    localparam logic [CHW-1:0] UF_DST_CH = CHW'(5);

    // Per-transfer cascade target of a channel.
    function automatic link_t next_link(input int unsigned ch);
        link_t l;
        l.valid = 1'b1;
        case (ch)
            0: l.ch = CHW'(1);
            1: l.ch = CHW'(2);
            2: l.ch = CHW'(0);
            3: l.ch = CHW'(4);
            5: l.ch = CHW'(6);
            6: l.ch = CHW'(7);
            7: l.ch = CHW'(5);
            8: l.ch = CHW'(9);
            default: begin
                l.valid = 1'b0;
                l.ch    = '0;
            end
        endcase
        return l;
    endfunction
endpackage

// File: rtl/dmarb_cascade.sv
// Module: turns one completion into the cascade hits it causes.
// Assumes done is already qualified by an active grant.
module dmarb_cascade
    import dmarb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           done,
    input  logic           underflow,
    input  logic [CHW-1:0] done_ch,
    output logic [NCH-1:0] hit
);
    // Decode the finished channel into its link target(s).
    always_comb begin
        hit = '0;
        for (int j = 0; j < NCH; j++) begin
            if (done && done_ch == CHW'(j) && next_link(j).valid)
                hit[next_link(j).ch] = 1'b1;
        end
        if (done && underflow && done_ch == UF_SRC_CH)
            hit[UF_DST_CH] = 1'b1;
    end

    AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> hit == '0);  // R5
    AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) <= 2);  // R7
endmodule

// File: rtl/dmarb_req_latch.sv
// Module: per-channel source selection and sticky pending bits.
// Assumes clr is one-hot at most; a new set in the clearing cycle wins.
module dmarb_req_latch
    import dmarb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ch_enable,
    input  logic [SELW*NCH-1:0] src_sel,
    input  logic [NCH-1:0]    sw_trig,
    input  logic [NCH-1:0]    periph_req,
    input  logic [NCH-1:0]    casc_hit,
    input  logic [NCH-1:0]    clr,
    output logic [NCH-1:0]    pending
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        src_sel_e sel;
        logic     set;

        // Pick the one source this channel listens to.
        always_comb begin
            sel = src_sel_e'(src_sel[SELW*i +: SELW]);
            case (sel)
                SRC_SW:      set = sw_trig[i];
                SRC_PERIPH:  set = periph_req[i];
                SRC_CASCADE: set = casc_hit[i];
                default:     set = 1'b0;
            endcase
            set = set & ch_enable[i];
        end

        // Hold the request until its transfer completes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pending[i] <= 1'b0;
            else if (set)
                pending[i] <= 1'b1;
            else if (clr[i])
                pending[i] <= 1'b0;
        end

        AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_enable[i] && !pending[i]) |=> !pending[i]);  // R8
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[i] && !clr[i]) |=> pending[i]);  // R4
    end
endmodule

// File: rtl/dmarb_prio_pick.sv
// Module: fixed-priority selector, lowest index wins.
// Assumes nothing about the pending vector; purely combinational.
module dmarb_prio_pick
    import dmarb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    output logic           pick_valid,
    output logic [CHW-1:0] pick_idx,
    output logic [NCH-1:0] pick_oh
);
    // Scan from the top so the lowest set bit is kept last.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        pick_oh    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_valid = 1'b1;
                pick_idx   = CHW'(i);
                pick_oh    = NCH'(1) << i;
            end
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ((req & (pick_oh - NCH'(1))) == '0) && ((req & pick_oh) != '0));  // R2
endmodule

// File: rtl/dma_req_arbiter.sv
// Module: top of the ten-channel request arbiter. Latches requests, grants
// one channel per transfer, feeds completions back as cascade requests.
// Assumes xfer_done is a single-cycle pulse per transfer from the datapath.
module dma_req_arbiter
    import dmarb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      ch_enable,
    input  logic [SELW*NCH-1:0] src_sel,
    input  logic [NCH-1:0]      sw_trig,
    input  logic [NCH-1:0]      periph_req,
    input  logic                xfer_done,
    input  logic                xfer_underflow,
    output logic                grant_valid,
    output logic [CHW-1:0]      grant_ch,
    output logic [NCH-1:0]      grant_onehot
);
    logic           done_q;
    logic [NCH-1:0] casc_hit;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] pending;
    logic           pick_valid;
    logic [CHW-1:0] pick_idx;
    logic [NCH-1:0] pick_oh;

    // A completion counts only while a grant is outstanding.
    always_comb begin
        done_q = xfer_done & grant_valid;
        clr    = done_q ? (NCH'(1) << grant_ch) : '0;
    end

    dmarb_cascade u_cascade (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done_q),
        .underflow (xfer_underflow),
        .done_ch   (grant_ch),
        .hit       (casc_hit)
    );

    dmarb_req_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_enable  (ch_enable),
        .src_sel    (src_sel),
        .sw_trig    (sw_trig),
        .periph_req (periph_req),
        .casc_hit   (casc_hit),
        .clr        (clr),
        .pending    (pending)
    );

    dmarb_prio_pick u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (pending),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_oh    (pick_oh)
    );

    // Grant register: hold per transfer, release, then re-arbitrate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_ch     <= '0;
            grant_onehot <= '0;
        end else if (grant_valid) begin
            if (xfer_done) begin
                grant_valid  <= 1'b0;
                grant_onehot <= '0;
            end
        end else if (pick_valid) begin
            grant_valid  <= 1'b1;
            grant_ch     <= pick_idx;
            grant_onehot <= pick_oh;
        end
    end

    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (pending & grant_onehot) != '0);  // R4
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> grant_valid && $stable(grant_ch));  // R9
    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done) |=> !grant_valid);  // R9
    AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $onehot0(grant_onehot) && grant_onehot[grant_ch]);  // R2
endmodule

// File: tb/dma_req_arbiter_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module dma_req_arbiter_tb_top;
    import dmarb_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH-1:0]      ch_enable = '1;
    logic [SELW*NCH-1:0] src_sel = '0;
    logic [NCH-1:0]      sw_trig = '0;
    logic [NCH-1:0]      periph_req = '0;
    logic                xfer_done = 1'b0;
    logic                xfer_underflow = 1'b0;
    logic                grant_valid;
    logic [CHW-1:0]      grant_ch;
    logic [NCH-1:0]      grant_onehot;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_req_arbiter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ch_enable      (ch_enable),
        .src_sel        (src_sel),
        .sw_trig        (sw_trig),
        .periph_req     (periph_req),
        .xfer_done      (xfer_done),
        .xfer_underflow (xfer_underflow),
        .grant_valid    (grant_valid),
        .grant_ch       (grant_ch),
        .grant_onehot   (grant_onehot)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_sel(input int ch, input logic [1:0] v);
        src_sel[SELW*ch +: SELW] = v;
    endtask

    task automatic expect_idle(input string req);
        n_checks++;
        if (grant_valid !== 1'b0 || grant_onehot !== '0) begin
            n_fail++;
            $display("FAIL %s: grant_valid=%0b onehot=%b, expected idle", req, grant_valid, grant_onehot);
        end
    endtask

    task automatic expect_grant(input int ch, input string req);
        n_checks++;
        if (grant_valid !== 1'b1 || grant_ch !== CHW'(ch) || grant_onehot !== (NCH'(1) << ch)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b ch=%0d onehot=%b, expected ch=%0d", req, grant_valid, grant_ch, grant_onehot, ch);
        end
    endtask

    task automatic pulse_sw(input logic [NCH-1:0] m);
        sw_trig = m;
        tick();
        sw_trig = '0;
    endtask

    // Completes the current transfer; the grant must drop at that edge.
    task automatic finish(input logic uf, input string req);
        xfer_done = 1'b1;
        xfer_underflow = uf;
        tick();
        xfer_done = 1'b0;
        xfer_underflow = 1'b0;
        expect_idle(req);
    endtask

    task automatic t_reset();
        expect_idle("R1");
        tick();
        expect_idle("R1");
    endtask

    task automatic t_priority();
        pulse_sw(NCH'(10'b0010001000));
        expect_idle("R2");
        tick();
        expect_grant(3, "R2");
        tick();
        tick();
        expect_grant(3, "R9");
        finish(1'b0, "R9");
        tick();
        expect_grant(7, "R4");
        finish(1'b0, "R9");
        tick();
        expect_idle("R4");
    endtask

    task automatic t_select();
        set_sel(2, 2'b01);
        pulse_sw(NCH'(1) << 2);
        tick();
        expect_idle("R3");
        periph_req = NCH'(1) << 2;
        tick();
        periph_req = '0;
        tick();
        expect_grant(2, "R3");
        finish(1'b0, "R3");
        set_sel(2, 2'b00);
        set_sel(4, 2'b11);
        sw_trig = NCH'(1) << 4;
        periph_req = NCH'(1) << 4;
        tick();
        sw_trig = '0;
        periph_req = '0;
        tick();
        expect_idle("R3");
        set_sel(4, 2'b10);
        pulse_sw(NCH'(1) << 4);
        tick();
        expect_idle("R3");
        set_sel(4, 2'b00);
        ch_enable[6] = 1'b0;
        pulse_sw(NCH'(1) << 6);
        tick();
        expect_idle("R8");
        ch_enable[6] = 1'b1;
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        tick();
        expect_idle("R9");
    endtask

    task automatic t_ring_low();
        set_sel(1, 2'b10);
        set_sel(2, 2'b10);
        pulse_sw(NCH'(1));
        tick();
        expect_grant(0, "R5");
        set_sel(0, 2'b10);
        finish(1'b0, "R5");
        tick();
        expect_grant(1, "R5");
        finish(1'b0, "R5");
        tick();
        expect_grant(2, "R5");
        finish(1'b0, "R5");
        tick();
        expect_grant(0, "R5");
        ch_enable[1] = 1'b0;
        finish(1'b0, "R8");
        tick();
        expect_idle("R8");
        set_sel(0, 2'b00);
    endtask

    task automatic t_ring_high();
        set_sel(5, 2'b10);
        set_sel(6, 2'b10);
        set_sel(7, 2'b10);
        pulse_sw(NCH'(1));
        tick();
        expect_grant(0, "R7");
        finish(1'b1, "R7");
        tick();
        expect_grant(5, "R7");
        finish(1'b0, "R5");
        tick();
        expect_grant(6, "R5");
        finish(1'b0, "R5");
        tick();
        expect_grant(7, "R5");
        finish(1'b0, "R5");
        tick();
        expect_grant(5, "R5");
        ch_enable[6] = 1'b0;
        finish(1'b0, "R8");
        tick();
        expect_idle("R8");
        ch_enable = '1;
    endtask

    task automatic t_pairs();
        set_sel(1, 2'b00);
        set_sel(2, 2'b00);
        set_sel(4, 2'b10);
        set_sel(9, 2'b10);
        pulse_sw(NCH'(1) << 3);
        tick();
        expect_grant(3, "R6");
        finish(1'b1, "R7");
        tick();
        expect_grant(4, "R6");
        finish(1'b1, "R6");
        tick();
        expect_idle("R7");
        pulse_sw(NCH'(1) << 8);
        tick();
        expect_grant(8, "R6");
        finish(1'b0, "R6");
        tick();
        expect_grant(9, "R6");
        finish(1'b0, "R6");
        tick();
        expect_idle("R6");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        t_reset();
        t_priority();
        t_select();
        t_ring_low();
        t_ring_high();
        t_pairs();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule